// File: doc/BRIEF.md
# Port-Mapped I/O Decoder

This block decodes a separate I/O address space for an 8-bit CPU bus. A port number is taken from the low byte of the address bus only. An I/O request strobe qualifies every access, so memory cycles that happen to carry a matching low byte never touch a port. Input ports and output ports live in two independent 256-entry spaces. The same number may name one input and one output at the same time.

Output ports are byte latches. A latch loads the write data at the clock edge that ends an I/O write cycle whose port number matches its own. Input ports are external bytes. The selected byte is driven onto the read bus during an I/O read cycle. When nothing is selected, the read bus rests at FFh. The port numbers of each space are set by parameters.

Top module: `pmio_decoder`

## Requirements
- R1: Only address bits 7..0 form the port number; address bits above bit 7 never change which port is selected.
- R2: While io_req_i and rd_i are both 1 and the port number equals the number of input port k (byte k of IN_MAP), rd_data_o equals byte k of in_ports_i in the same cycle.
- R3: During an I/O read whose port number matches no input port, rd_data_o is FFh.
- R4: When io_req_i and wr_i are both 1 at a rising clock edge and the port number equals the number of output port k (byte k of OUT_MAP), byte k of out_ports_o holds data_i from that edge on.
- R5: Every output latch is 00h after reset and keeps its value until a matching I/O write.
- R6: With io_req_i at 0 (a memory cycle), no output latch changes, io_rd_o is 0 and rd_data_o is FFh, whatever the address and strobes.
- R7: The input and output spaces are separate: a write to a number that names both an input and an output leaves the input read value unchanged, and a read of a number that names only an output port returns FFh.
- R8: io_rd_o is 1 exactly while io_req_i and rd_i are both 1.
- R9: An I/O write to a port number that names no output port leaves all output latches unchanged.
- R10: Whenever io_rd_o is 0, rd_data_o is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (16) | CPU address bus |
| data_i | input | 8 | CPU write data |
| io_req_i | input | 1 | I/O request strobe, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| in_ports_i | input | 8*N_IN (16) | External input bytes, port k in byte k |
| rd_data_o | output | 8 | Read data toward the CPU |
| io_rd_o | output | 1 | Combined I/O read enable |
| out_ports_o | output | 8*N_OUT (24) | Latched output bytes, port k in byte k |

## Verification
A latch that loads on the wrong cycle or from the wrong match shows on out_ports_o one cycle after the offending write edge. The bench compares all latches after every access, memory cycles and unmapped writes included. The read path has no state, so a wrong select or a missing qualification shows on rd_data_o in the same cycle as the read. The bench samples it before the next edge. Reset values show on the latch outputs before the first access.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
  typedef logic [7:0] port_num_t;
  typedef logic [7:0] bus_byte_t;
  localparam bus_byte_t IDLE_BYTE = 8'hFF;
  localparam bus_byte_t LATCH_RST = 8'h00;
endpackage

// File: rtl/pmio_match.sv
module pmio_match
  import pmio_pkg::*;
#(
  parameter int unsigned N   = 2,
  parameter logic [N*8-1:0] MAP = '0
) (
  input  port_num_t      port_i,
  input  logic           en_i,
  output logic [N-1:0]   hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = en_i && (port_i == MAP[g*8 +: 8]);
  end
endmodule

// File: rtl/pmio_out_latch.sv
module pmio_out_latch
  import pmio_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  bus_byte_t d_i,
  output bus_byte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= LATCH_RST;
    else if (we_i) q_o <= d_i;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/pmio_rd_mux.sv
module pmio_rd_mux
  import pmio_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0]   hit_i,
  input  logic [N*8-1:0] in_bus_i,
  output bus_byte_t      data_o
);
  // lowest index wins if the map holds a duplicate number
  always_comb begin
    data_o = IDLE_BYTE;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) data_o = in_bus_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/pmio_decoder.sv
module pmio_decoder
  import pmio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned N_IN    = 2,
  parameter int unsigned N_OUT   = 3,
  parameter logic [N_IN*8-1:0]  IN_MAP  = {8'h05, 8'h02},
  parameter logic [N_OUT*8-1:0] OUT_MAP = {8'hFF, 8'h02, 8'h03}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  input  logic               io_req_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [N_IN*8-1:0]  in_ports_i,
  output logic [7:0]         rd_data_o,
  output logic               io_rd_o,
  output logic [N_OUT*8-1:0] out_ports_o
);
  port_num_t        port_num;
  logic             io_wr;
  logic [N_IN-1:0]  in_hit;
  logic [N_OUT-1:0] out_hit;
  logic             unused_hi_addr;

  assign port_num       = addr_i[7:0];
  assign unused_hi_addr = ^addr_i[ADDR_W-1:8];
  assign io_rd_o        = io_req_i & rd_i;
  assign io_wr          = io_req_i & wr_i;

  pmio_match #(.N(N_IN), .MAP(IN_MAP)) i_in_match (
    .port_i (port_num),
    .en_i   (io_rd_o),
    .hit_o  (in_hit)
  );

  pmio_match #(.N(N_OUT), .MAP(OUT_MAP)) i_out_match (
    .port_i (port_num),
    .en_i   (io_wr),
    .hit_o  (out_hit)
  );

  pmio_rd_mux #(.N(N_IN)) i_rd_mux (
    .hit_i    (in_hit),
    .in_bus_i (in_ports_i),
    .data_o   (rd_data_o)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pmio_out_latch i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (out_hit[g]),
      .d_i    (data_i),
      .q_o    (out_ports_o[g*8 +: 8])
    );
  end

  AST_IDLE_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_o |-> rd_data_o == IDLE_BYTE); // R10
  AST_MISS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hit == '0) |-> rd_data_o == IDLE_BYTE); // R3
  AST_MEM_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_req_i |=> $stable(out_ports_o)); // R6
  AST_NO_HIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_hit == '0) |=> $stable(out_ports_o)); // R9
endmodule

// File: tb/test_pmio_decoder.sv
module test_pmio_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        io_req = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] in_ports = 16'h0000;
  logic [7:0]  rd_data;
  logic        io_rd;
  logic [23:0] out_ports;

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_out = 24'h000000;

  always #2 clk = ~clk;

  pmio_decoder i_pmio_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdata),
    .io_req_i(io_req), .rd_i(rd), .wr_i(wr), .in_ports_i(in_ports),
    .rd_data_o(rd_data), .io_rd_o(io_rd), .out_ports_o(out_ports)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output port numbers: byte0=03h, byte1=02h, byte2=FFh
  function automatic int out_idx(input logic [7:0] p);
    case (p)
      8'h03: return 0;
      8'h02: return 1;
      8'hFF: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic ioq, input string tag);
    int k;
    @(negedge clk);
    addr = a; wdata = d; io_req = ioq; wr = 1'b1; rd = 1'b0;
    #1 chk({tag, " rd idle"}, {24'h0, rd_data}, 32'hFF);
    @(negedge clk);
    io_req = 1'b0; wr = 1'b0;
    k = out_idx(a[7:0]);
    if (ioq && k >= 0) exp_out[k*8 +: 8] = d;
    chk({tag, " latches"}, {8'h0, out_ports}, {8'h0, exp_out});
  endtask

  task automatic bus_read(input logic [15:0] a, input logic ioq, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; io_req = ioq; rd = 1'b1; wr = 1'b0;
    #1;
    chk({tag, " data"}, {24'h0, rd_data}, {24'h0, exp});
    chk({tag, " io_rd R8"}, {31'h0, io_rd}, {31'h0, ioq});
    @(negedge clk);
    io_req = 1'b0; rd = 1'b0;
    chk({tag, " latches kept"}, {8'h0, out_ports}, {8'h0, exp_out});
  endtask

  task automatic t_reset;
    #1;
    chk("R5 reset latches", {8'h0, out_ports}, 32'h0);
    chk("R10 reset rd idle", {24'h0, rd_data}, 32'hFF);
    chk("R8 reset io_rd", {31'h0, io_rd}, 32'h0);
  endtask

  task automatic t_writes;
    bus_write(16'hA503, 8'h5A, 1'b1, "R4 R1 write 03h upper A5");
    bus_write(16'h0002, 8'hC3, 1'b1, "R4 write 02h");
    bus_write(16'h12FF, 8'h81, 1'b1, "R4 write FFh edge");
    bus_write(16'hFF03, 8'h17, 1'b1, "R1 overwrite 03h upper FF");
  endtask

  task automatic t_ignored_writes;
    bus_write(16'h0040, 8'hEE, 1'b1, "R9 unmapped 40h");
    bus_write(16'h0005, 8'hEE, 1'b1, "R9 input-only 05h");
    bus_write(16'h0003, 8'h99, 1'b0, "R6 memory write 03h");
    bus_write(16'h00FF, 8'h99, 1'b0, "R6 memory write FFh");
    repeat (3) @(negedge clk);
    chk("R5 hold idle", {8'h0, out_ports}, {8'h0, exp_out});
  endtask

  task automatic t_reads;
    in_ports = 16'h3CA7;  // 05h -> 3Ch, 02h -> A7
    bus_read(16'h0002, 1'b1, 8'hA7, "R2 read 02h");
    bus_read(16'hBE02, 1'b1, 8'hA7, "R1 read 02h upper BE");
    bus_read(16'h7705, 1'b1, 8'h3C, "R2 read 05h");
    in_ports = 16'h0155;
    bus_read(16'h0005, 1'b1, 8'h01, "R2 new pattern 05h");
    bus_read(16'h0003, 1'b1, 8'hFF, "R7 R3 output-only 03h");
    bus_read(16'h0077, 1'b1, 8'hFF, "R3 unmapped 77h");
    bus_read(16'h0002, 1'b0, 8'hFF, "R6 memory read 02h");
  endtask

  task automatic t_shared_number;
    in_ports = 16'h0066;
    bus_write(16'h0002, 8'h44, 1'b1, "R7 write shared 02h");
    bus_read(16'h0002, 1'b1, 8'h66, "R7 input 02h unchanged");
    chk("R7 output 02h", {24'h0, out_ports[15:8]}, 32'h44);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_writes();
    t_ignored_writes();
    t_reads();
    t_shared_number();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule